// File: doc/BRIEF.md
# Switch Companion SPI Control Register with Guarded Low-Power Entry

This block is the 8-bit SPI slave register of a companion chip that drives high-side switches and a bus transceiver. Every transfer moves one command byte in on MOSI and one status byte out on MISO at the same time. The command byte carries four settings. The first is a 2-bit slew code that either selects the bus edge rate or asks for low power. The second is a pullup policy bit for the low-power states. The third is one enable per high-side output. The last is a 2-bit mode field that services the watchdog or names the low-power state wanted.

Sleep or Stop is never entered from a single frame. A frame that carries the low-power slew code only arms the request. The frame that follows must name Sleep or Stop to commit it, and any other frame drops the request. The status byte reports latched fault and wake events. A flag is cleared only by the frame that actually carried it out. On the first read after either kind of reset, the undervoltage position carries a battery-fail flag instead.

The SPI pins are sampled by the system clock through synchronizers, so the SPI clock must be several times slower than the system clock.

Top module: `swc_spi_ctrl`

## Requirements
- R1: A frame is applied only when exactly 8 rising SPI clock edges occur while `spi_csn` is low; MOSI is taken MSB first on rising edges; frames of any other length change no output, no pulse count and no status flag.
- R2: Command byte fields: bits 7:6 slew code, bit 5 pullup disable, bits 4:2 output enables (bit 2 drives `hs_en[0]`, bit 4 drives `hs_en[2]`), bits 1:0 mode code.
- R3: Slew codes 00 (normal), 01 (slow) and 10 (fast download) are copied to `slew_sel`; code 11 (low-power request) is never stored, and the previous slew setting is kept.
- R4: A valid frame with slew code 11 arms a low-power request. If the very next valid frame has mode 00 (Sleep) or 01 (Stop), `lp_enter` pulses for one clock and `lp_stop` takes mode bit 0. Any other frame disarms the request. A single frame never produces `lp_enter`.
- R5: Mode 10 in a valid frame gives exactly one single-clock `wd_clr` pulse. Mode 11, and modes 00/01 that do not commit, give no pulse.
- R6: Power-on reset (`rst_n`) clears every output. The functional reset (`func_rst_n` low, synchronous) clears slew, enables, the armed state and `lp_stop`, but leaves `pullup_dis` unchanged.
- R7: Status byte: bit 6 bus wake/fail, bit 5 high voltage, bit 4 low voltage, bit 3 temperature warning, bit 2 output shutdown, bits 1:0 zero, and bit 7 set exactly when any of bits 6:2 is set.
- R8: An event input that is high in any clock sets its flag. A flag is cleared when a valid frame that reported it completes. Flags that the frame did not report, or that a discarded frame showed, stay set.
- R9: The first valid frame after either reset reports the battery-fail flag on bit 4. Every later frame reports the low-voltage flag there.
- R10: MISO presents status bit 7 after `spi_csn` falls and the next lower bit after each falling SPI clock edge (SPI mode 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, asynchronous active low |
| func_rst_n | input | 1 | Functional reset, synchronous active low |
| spi_sclk | input | 1 | SPI clock, idles low |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Command data in |
| spi_miso | output | 1 | Status data out |
| ev_bus | input | 1 | Bus wake-up or bus failure event |
| ev_hv | input | 1 | High-voltage fault event |
| ev_lv | input | 1 | Low-voltage fault event |
| ev_batf | input | 1 | Battery-fail event |
| ev_temp | input | 1 | Temperature warning event |
| ev_hs_sd | input | 1 | High-side shutdown event |
| slew_sel | output | 2 | Applied bus slew code |
| pullup_dis | output | 1 | Disconnect bus pullup in Sleep/Stop |
| hs_en | output | 3 | High-side output enables |
| wd_clr | output | 1 | Watchdog service pulse |
| lp_enter | output | 1 | Low-power entry strobe |
| lp_stop | output | 1 | Committed state: 1 Stop, 0 Sleep |

## Verification
An armed flag that is stuck set or cleared too early shows as an extra or missing `lp_enter` on the second frame of a pair. The sweep over all 256 command bytes in order reaches this within one frame. A wrong first-read marker or a wrong report mask shows on MISO in the very next read: the wrong source appears on bit 4, or a flag returns or vanishes. A stored low-power slew code shows on `slew_sel` a few clocks after chip select rises.

// File: rtl/swc_pkg.sv
package swc_pkg;
  localparam int NUM_HS     = 3;
  localparam int FRAME_BITS = 2 + 1 + NUM_HS + 2;
  localparam int SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    SLEW_NORM = 2'b00,
    SLEW_SLOW = 2'b01,
    SLEW_FAST = 2'b10,
    SLEW_LP   = 2'b11
  } slew_e;

  typedef enum logic [1:0] {
    MODE_SLEEP = 2'b00,
    MODE_STOP  = 2'b01,
    MODE_WDCLR = 2'b10,
    MODE_RUN   = 2'b11
  } mode_e;

  typedef struct packed {
    slew_e             slew;
    logic              pu_dis;
    logic [NUM_HS-1:0] hs;
    mode_e             mode;
  } ctl_byte_t;

  // flag storage indices
  localparam int F_BUS  = 0;
  localparam int F_HV   = 1;
  localparam int F_LV   = 2;
  localparam int F_BATF = 3;
  localparam int F_TEMP = 4;
  localparam int F_SD   = 5;
  localparam int NFLAG  = 6;

  // status byte bit positions
  localparam int ST_IRQ  = 7;
  localparam int ST_BUS  = 6;
  localparam int ST_HV   = 5;
  localparam int ST_LV   = 4;
  localparam int ST_TEMP = 3;
  localparam int ST_SD   = 2;
endpackage

// File: rtl/swc_spi_shifter.sv
module swc_spi_shifter #(
  parameter int FRAME_BITS  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  srst,
  input  logic                  sclk,
  input  logic                  csn,
  input  logic                  mosi,
  input  logic [FRAME_BITS-1:0] tx_word,
  output logic                  miso,
  output logic                  frame_start,
  output logic                  frame_done,
  output logic [FRAME_BITS-1:0] rx_word
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

  logic [SYNC_STAGES-1:0] sclk_sy, csn_sy, mosi_sy;
  logic sclk_q, csn_q;
  logic sclk_s, csn_s, mosi_s;
  logic sclk_rise, sclk_fall, cs_fall, cs_rise;

  logic [FRAME_BITS-1:0] rx_q, rx_n, tx_q, tx_n;
  logic [CNT_W-1:0]      cnt_q, cnt_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sy <= '0;
      csn_sy  <= '1;
      mosi_sy <= '0;
      sclk_q  <= 1'b0;
      csn_q   <= 1'b1;
    end else begin
      sclk_sy <= {sclk_sy[SYNC_STAGES-2:0], sclk};
      csn_sy  <= {csn_sy[SYNC_STAGES-2:0], csn};
      mosi_sy <= {mosi_sy[SYNC_STAGES-2:0], mosi};
      sclk_q  <= sclk_s;
      csn_q   <= csn_s;
    end
  end

  assign sclk_s    = sclk_sy[SYNC_STAGES-1];
  assign csn_s     = csn_sy[SYNC_STAGES-1];
  assign mosi_s    = mosi_sy[SYNC_STAGES-1];
  assign sclk_rise = sclk_s & ~sclk_q;
  assign sclk_fall = ~sclk_s & sclk_q;
  assign cs_fall   = ~csn_s & csn_q;
  assign cs_rise   = csn_s & ~csn_q;

  always_comb begin
    rx_n  = rx_q;
    tx_n  = tx_q;
    cnt_n = cnt_q;
    if (srst) begin
      rx_n  = '0;
      tx_n  = '0;
      cnt_n = '0;
    end else if (cs_fall) begin
      tx_n  = tx_word;
      cnt_n = '0;
    end else if (!csn_s) begin
      if (sclk_rise) begin
        rx_n = {rx_q[FRAME_BITS-2:0], mosi_s};
        if (cnt_q != CNT_MAX) cnt_n = cnt_q + 1'b1;
      end else if (sclk_fall) begin
        tx_n = {tx_q[FRAME_BITS-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q  <= '0;
      tx_q  <= '0;
      cnt_q <= '0;
    end else begin
      rx_q  <= rx_n;
      tx_q  <= tx_n;
      cnt_q <= cnt_n;
    end
  end

  assign frame_start = cs_fall & ~srst;
  assign frame_done  = cs_rise & ~srst & (cnt_q == CNT_FULL);
  assign rx_word     = rx_q;
  assign miso        = tx_q[FRAME_BITS-1];
endmodule

// File: rtl/swc_ctl_decode.sv
module swc_ctl_decode
  import swc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              frame_done,
  input  ctl_byte_t         cmd,
  output logic [1:0]        slew_sel,
  output logic              pullup_dis,
  output logic [NUM_HS-1:0] hs_en,
  output logic              wd_clr,
  output logic              lp_enter,
  output logic              lp_stop,
  output logic              armed
);
  logic [1:0]        slew_q, slew_n;
  logic              pu_q, pu_n;
  logic [NUM_HS-1:0] hs_q, hs_n;
  logic              arm_q, arm_n;
  logic              wd_q, wd_n;
  logic              lp_q, lp_n;
  logic              stop_q, stop_n;

  always_comb begin
    slew_n = slew_q;
    pu_n   = pu_q;
    hs_n   = hs_q;
    arm_n  = arm_q;
    stop_n = stop_q;
    wd_n   = 1'b0;
    lp_n   = 1'b0;
    if (frame_done) begin
      hs_n = cmd.hs;
      pu_n = cmd.pu_dis;
      if (cmd.slew != SLEW_LP) slew_n = cmd.slew;
      if (arm_q && (cmd.mode == MODE_SLEEP || cmd.mode == MODE_STOP)) begin
        lp_n   = 1'b1;
        stop_n = (cmd.mode == MODE_STOP);
        arm_n  = 1'b0;
      end else begin
        arm_n = (cmd.slew == SLEW_LP);
      end
      wd_n = (cmd.mode == MODE_WDCLR);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slew_q <= '0;
      pu_q   <= 1'b0;
      hs_q   <= '0;
      arm_q  <= 1'b0;
      wd_q   <= 1'b0;
      lp_q   <= 1'b0;
      stop_q <= 1'b0;
    end else if (srst) begin
      slew_q <= '0;
      hs_q   <= '0;
      arm_q  <= 1'b0;
      wd_q   <= 1'b0;
      lp_q   <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      slew_q <= slew_n;
      pu_q   <= pu_n;
      hs_q   <= hs_n;
      arm_q  <= arm_n;
      wd_q   <= wd_n;
      lp_q   <= lp_n;
      stop_q <= stop_n;
    end
  end

  assign slew_sel   = slew_q;
  assign pullup_dis = pu_q;
  assign hs_en      = hs_q;
  assign wd_clr     = wd_q;
  assign lp_enter   = lp_q;
  assign lp_stop    = stop_q;
  assign armed      = arm_q;
endmodule

// File: rtl/swc_status_latch.sv
module swc_status_latch
  import swc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic             frame_start,
  input  logic             frame_done,
  input  logic [NFLAG-1:0] ev,
  output logic [7:0]       stat_word
);
  logic [NFLAG-1:0] flg_q, flg_n;
  logic [NFLAG-1:0] rep_q, rep_n;
  logic [NFLAG-1:0] sel_now, shown;
  logic             first_q, first_n;

  always_comb begin
    sel_now = '1;
    if (first_q) sel_now[F_LV]   = 1'b0;
    else         sel_now[F_BATF] = 1'b0;
    shown = flg_q & sel_now;
  end

  always_comb begin
    stat_word          = '0;
    stat_word[ST_BUS]  = shown[F_BUS];
    stat_word[ST_HV]   = shown[F_HV];
    stat_word[ST_LV]   = shown[F_LV] | shown[F_BATF];
    stat_word[ST_TEMP] = shown[F_TEMP];
    stat_word[ST_SD]   = shown[F_SD];
    stat_word[ST_IRQ]  = |shown;
  end

  always_comb begin
    flg_n   = flg_q | ev;
    rep_n   = rep_q;
    first_n = first_q;
    if (frame_done) begin
      flg_n   = (flg_q & ~rep_q) | ev;
      first_n = 1'b0;
    end
    if (frame_start) rep_n = shown;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q   <= '0;
      rep_q   <= '0;
      first_q <= 1'b1;
    end else if (srst) begin
      flg_q   <= flg_n;
      rep_q   <= '0;
      first_q <= 1'b1;
    end else begin
      flg_q   <= flg_n;
      rep_q   <= rep_n;
      first_q <= first_n;
    end
  end
endmodule

// File: rtl/swc_spi_ctrl.sv
module swc_spi_ctrl
  import swc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              func_rst_n,
  input  logic              spi_sclk,
  input  logic              spi_csn,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic              ev_bus,
  input  logic              ev_hv,
  input  logic              ev_lv,
  input  logic              ev_batf,
  input  logic              ev_temp,
  input  logic              ev_hs_sd,
  output logic [1:0]        slew_sel,
  output logic              pullup_dis,
  output logic [NUM_HS-1:0] hs_en,
  output logic              wd_clr,
  output logic              lp_enter,
  output logic              lp_stop
);
  logic [1:0]            rst_sy;
  logic                  rst_int;
  logic                  srst;
  logic                  frame_start, frame_done;
  logic [FRAME_BITS-1:0] rx_word;
  logic [7:0]            stat_word;
  logic [NFLAG-1:0]      ev_vec;
  logic                  armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sy <= '0;
    else        rst_sy <= {rst_sy[0], 1'b1};
  end
  assign rst_int = rst_sy[1];
  assign srst    = ~func_rst_n;

  always_comb begin
    ev_vec         = '0;
    ev_vec[F_BUS]  = ev_bus;
    ev_vec[F_HV]   = ev_hv;
    ev_vec[F_LV]   = ev_lv;
    ev_vec[F_BATF] = ev_batf;
    ev_vec[F_TEMP] = ev_temp;
    ev_vec[F_SD]   = ev_hs_sd;
  end

  swc_spi_shifter #(
    .FRAME_BITS (FRAME_BITS),
    .SYNC_STAGES(SYNC_STAGES)
  ) shifter_i (
    .clk        (clk),
    .rst_n      (rst_int),
    .srst       (srst),
    .sclk       (spi_sclk),
    .csn        (spi_csn),
    .mosi       (spi_mosi),
    .tx_word    (stat_word),
    .miso       (spi_miso),
    .frame_start(frame_start),
    .frame_done (frame_done),
    .rx_word    (rx_word)
  );

  swc_ctl_decode decode_i (
    .clk       (clk),
    .rst_n     (rst_int),
    .srst      (srst),
    .frame_done(frame_done),
    .cmd       (ctl_byte_t'(rx_word)),
    .slew_sel  (slew_sel),
    .pullup_dis(pullup_dis),
    .hs_en     (hs_en),
    .wd_clr    (wd_clr),
    .lp_enter  (lp_enter),
    .lp_stop   (lp_stop),
    .armed     (armed)
  );

  swc_status_latch status_i (
    .clk        (clk),
    .rst_n      (rst_int),
    .srst       (srst),
    .frame_start(frame_start),
    .frame_done (frame_done),
    .ev         (ev_vec),
    .stat_word  (stat_word)
  );
endmodule

// File: rtl/swc_spi_ctrl_chk.sv
module swc_spi_ctrl_chk
  import swc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              srst,
  input logic              frame_done,
  input logic              armed,
  input logic [1:0]        slew_sel,
  input logic              pullup_dis,
  input logic [NUM_HS-1:0] hs_en,
  input logic              wd_clr,
  input logic              lp_enter
);
  a_r3_slew_never_lp: assert property (@(posedge clk) disable iff (!rst_n)
    slew_sel != 2'b11);

  a_r4_commit_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    lp_enter |-> $past(armed));

  a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    lp_enter |=> !lp_enter);

  a_r5_wd_single: assert property (@(posedge clk) disable iff (!rst_n)
    wd_clr |=> !wd_clr);

  a_r5_wd_lp_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(wd_clr && lp_enter));

  a_r1_hold_without_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_done && !srst) |=> $stable(hs_en));

  a_r6_pullup_survives_func_rst: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> $stable(pullup_dis));
endmodule

bind swc_spi_ctrl swc_spi_ctrl_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_int),
  .srst      (srst),
  .frame_done(frame_done),
  .armed     (armed),
  .slew_sel  (slew_sel),
  .pullup_dis(pullup_dis),
  .hs_en     (hs_en),
  .wd_clr    (wd_clr),
  .lp_enter  (lp_enter)
);

// File: tb/swc_spi_ctrl_tb_top.sv
`timescale 1ns/1ps
module swc_spi_ctrl_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, func_rst_n, sclk, csn, mosi, miso;
  logic [5:0] ev_drv; // 0 bus,1 hv,2 lv,3 batf,4 temp,5 shutdown
  logic [1:0] slew_sel;
  logic pullup_dis, wd_clr, lp_enter, lp_stop;
  logic [2:0] hs_en;

  int checks = 0;
  int fails  = 0;
  int wd_seen = 0;
  int lp_seen = 0;
  logic lp_kind = 1'b0;
  bit finished = 1'b0;

  swc_spi_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .func_rst_n(func_rst_n),
    .spi_sclk(sclk), .spi_csn(csn), .spi_mosi(mosi), .spi_miso(miso),
    .ev_bus(ev_drv[0]), .ev_hv(ev_drv[1]), .ev_lv(ev_drv[2]),
    .ev_batf(ev_drv[3]), .ev_temp(ev_drv[4]), .ev_hs_sd(ev_drv[5]),
    .slew_sel(slew_sel), .pullup_dis(pullup_dis), .hs_en(hs_en),
    .wd_clr(wd_clr), .lp_enter(lp_enter), .lp_stop(lp_stop)
  );

  always @(negedge clk) begin
    if (wd_clr) wd_seen++;
    if (lp_enter) begin
      lp_seen++;
      lp_kind = lp_stop;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    @(negedge clk) csn = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 8) ? tx[3'(7 - i)] : 1'b0;
      repeat (8) @(negedge clk);
      if (i < 8) rx[3'(7 - i)] = miso;
      sclk = 1'b1;
      repeat (8) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (8) @(negedge clk);
    csn = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic func_reset();
    @(negedge clk) func_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    func_rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_ev(input logic [5:0] v);
    @(negedge clk) ev_drv = v;
    repeat (2) @(negedge clk);
    ev_drv = '0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx;
    logic [1:0] m_slew;
    logic m_pu, m_arm, m_kind;
    logic [2:0] m_hs;
    int e_wd, e_lp, base_wd, base_lp;
    logic [7:0] exp_st;

    rst_n = 1'b0; func_rst_n = 1'b1; csn = 1'b1; sclk = 1'b0; mosi = 1'b0; ev_drv = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R6 reset state
    chk(slew_sel == 2'b00, "R6 por slew", slew_sel, 0);
    chk(hs_en == 3'b000, "R6 por hs_en", hs_en, 0);
    chk(pullup_dis == 1'b0, "R6 por pullup", pullup_dis, 0);
    chk(!wd_clr && !lp_enter && !lp_stop, "R6 por pulses", {wd_clr, lp_enter, lp_stop}, 0);

    // R7 R9 first read after power-on, no events
    xfer(8'h03, 8, rx);
    chk(rx == 8'h00, "R9 first read clean", rx, 0);

    // R2 R6 functional reset keeps pullup only
    xfer(8'h7F, 8, rx);
    chk(slew_sel == 2'b01 && pullup_dis && hs_en == 3'b111, "R2 field map",
        {slew_sel, pullup_dis, hs_en}, 6'b01_1_111);
    func_reset();
    chk(pullup_dis == 1'b1, "R6 func keeps pullup", pullup_dis, 1);
    chk(hs_en == 3'b000 && slew_sel == 2'b00, "R6 func clears", {slew_sel, hs_en}, 0);

    // R9 battery fail reported on first read, then low voltage
    pulse_ev(6'b001100);
    xfer(8'h03, 8, rx);
    chk(rx == 8'h90, "R9 first read batfail", rx, 8'h90);
    xfer(8'h03, 8, rx);
    chk(rx == 8'h90, "R9 second read lv", rx, 8'h90);
    xfer(8'h03, 8, rx);
    chk(rx == 8'h00, "R8 cleared after report", rx, 0);
    func_reset();
    pulse_ev(6'b000100);
    xfer(8'h03, 8, rx);
    chk(rx == 8'h00, "R9 first read hides lv", rx, 0);
    xfer(8'h03, 8, rx);
    chk(rx == 8'h90, "R9 lv after first read", rx, 8'h90);

    // R7 R8 R10 sweep over all event combinations
    for (int s = 0; s < 32; s++) begin
      logic [4:0] sv;
      sv = 5'(s);
      pulse_ev({sv[4], sv[3], 1'b0, sv[2], sv[1], sv[0]});
      exp_st = {|sv, sv[0], sv[1], sv[2], sv[3], sv[4], 2'b00};
      xfer(8'h03, 8, rx);
      chk(rx == exp_st, "R7 R10 status byte", rx, exp_st);
      xfer(8'h03, 8, rx);
      chk(rx == 8'h00, "R8 flags cleared", rx, 0);
    end

    // R1 discarded frames
    xfer(8'h03, 8, rx);
    base_wd = wd_seen;
    xfer(8'h7E, 7, rx);
    chk(hs_en == 0 && !pullup_dis && slew_sel == 0, "R1 short frame ignored",
        {slew_sel, pullup_dis, hs_en}, 0);
    xfer(8'h7E, 9, rx);
    chk(hs_en == 0 && !pullup_dis && slew_sel == 0, "R1 long frame ignored",
        {slew_sel, pullup_dis, hs_en}, 0);
    chk(wd_seen == base_wd, "R1 no wd from bad frames", wd_seen, base_wd);
    pulse_ev(6'b010000);
    xfer(8'h03, 7, rx);
    xfer(8'h03, 8, rx);
    chk(rx == 8'h88, "R8 flag kept over bad frame", rx, 8'h88);

    // R4 arming sequences
    base_lp = lp_seen;
    xfer(8'hC3, 8, rx);
    xfer(8'h03, 8, rx);
    xfer(8'h00, 8, rx);
    chk(lp_seen == base_lp, "R4 disarm blocks entry", lp_seen, base_lp);
    xfer(8'hC0, 8, rx);
    chk(lp_seen == base_lp, "R4 single frame no entry", lp_seen, base_lp);
    xfer(8'h01, 8, rx);
    chk(lp_seen == base_lp + 1 && lp_kind == 1'b1, "R4 stop commit",
        lp_seen - base_lp, 1);
    chk(slew_sel == 2'b00, "R3 slew after commit", slew_sel, 0);
    xfer(8'hC3, 8, rx);
    xfer(8'h00, 8, rx);
    chk(lp_seen == base_lp + 2 && lp_kind == 1'b0, "R4 sleep commit",
        lp_seen - base_lp, 2);

    // R2 R3 R4 R5 sweep over every command byte with a running model
    xfer(8'h03, 8, rx);
    m_slew = 2'b00; m_pu = 1'b0; m_hs = 3'b000; m_arm = 1'b0; m_kind = 1'b0;
    e_wd = wd_seen; e_lp = lp_seen;
    for (int b = 0; b < 256; b++) begin
      logic [7:0] cb;
      cb = 8'(b);
      if (m_arm && !cb[1]) begin
        e_lp++;
        m_kind = cb[0];
        m_arm = 1'b0;
      end else begin
        m_arm = (cb[7:6] == 2'b11);
      end
      if (cb[7:6] != 2'b11) m_slew = cb[7:6];
      m_pu = cb[5];
      m_hs = cb[4:2];
      if (cb[1:0] == 2'b10) e_wd++;
      xfer(cb, 8, rx);
      chk(hs_en == m_hs, "R2 enables", hs_en, m_hs);
      chk(pullup_dis == m_pu, "R2 pullup", pullup_dis, m_pu);
      chk(slew_sel == m_slew, "R3 slew", slew_sel, m_slew);
      chk(wd_seen == e_wd, "R5 wd pulses", wd_seen, e_wd);
      chk(lp_seen == e_lp, "R4 lp strobes", lp_seen, e_lp);
      if (e_lp > 0) chk(lp_kind == m_kind, "R4 lp kind", lp_kind, m_kind);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule